// File: doc/BRIEF.md
# Paced Byte Port with Transfer Counter

This block lets a host processor move bytes between itself and a small byte buffer through a single data port. The port takes 8-bit or 16-bit accesses. A data-request output paces the accesses. Firmware programs a 24-bit transfer count as three byte-wide staging registers. A command strobe then copies the staged value into the live counter. A setup strobe arms a transfer: it sets the buffer pointer and loads a remaining-length counter. Each accepted access then advances the pointer and shrinks the remaining length. Writes also consume the live transfer count. When the remaining length runs out, the request line drops and a one-cycle done pulse marks the end of the transfer. A back-side byte port reads and writes the same buffer on behalf of the logic that produces or consumes the data.

The controller is a three-state machine:

- **IDLE**: no request is outstanding.
- **XFER**: `drq` is high and port accesses are taken.
- **FINISH**: a single cycle that drives `done`.

The transitions are:

- **ARM** (IDLE→XFER): a setup strobe with a non-zero resulting length.
- **RELOAD** (XFER→XFER): a setup strobe during a transfer with a non-zero length.
- **ABORT** (XFER→IDLE): a setup strobe during a transfer with a zero length.
- **DRAIN** (XFER→FINISH): the access that consumes the last remaining byte.
- **RETIRE** (FINISH→IDLE): the cycle after FINISH, or **ARM** again if a setup strobe arrives in FINISH.

Top module: `pdma_port`

## Requirements
- R1: After reset `drq`, `done`, `tc_flag`, `rem_len`, `cur_ptr` and `xfer_count` are all zero.
- R2: A count-byte write stages a byte and leaves `xfer_count` unchanged.
  - Select 0 stages bits 7:0, select 1 stages bits 15:8, and select 2 stages bits 23:16.
  - Select 3 changes nothing.
  - A `cmd_dma_load` strobe copies the three staged bytes into `xfer_count`.
- R3: A count-byte write with select 0, 1 or 2 clears `tc_flag`.
- R4: A setup strobe sets `cur_ptr` to `setup_ptr`.
  - It sets `rem_len` to the smaller of `setup_len` and the effective count. The effective count is 65536 when `xfer_count` is zero and `xfer_count` otherwise.
  - `drq` is high from the next cycle exactly when the loaded length is non-zero.
- R5: An accepted 8-bit write does the following:
  - It stores `port_wdata[7:0]` at `cur_ptr`.
  - It adds 1 to `cur_ptr`.
  - It subtracts 1 from both `rem_len` and `xfer_count`.
- R6: An accepted 16-bit write stores `port_wdata[15:8]` at `cur_ptr` and `port_wdata[7:0]` at `cur_ptr+1`. It moves the pointer and both counters by 2. If `rem_len` or `xfer_count` is 1, only the high byte is stored and everything moves by 1.
- R7: A port write has no effect when `xfer_count` or `rem_len` is zero.
- R8: An accepted read subtracts from `rem_len` and never changes `xfer_count`. The next cycle shows the result on `port_rdata`:
  - An 8-bit read gives `{8'h00, byte}`.
  - A 16-bit read gives `{buf[ptr], buf[ptr+1]}`, or `{buf[ptr], 8'h00}` when only one byte remains.
- R9: A read with `rem_len` zero returns 0 and changes no counter or pointer.
- R10: The access that brings `rem_len` to zero drops `drq` and raises `done` for exactly one cycle. `done` rises at no other time.
- R11: A port write that brings `xfer_count` to zero sets `tc_flag`.
- R12: `cur_ptr` and the buffer addresses wrap modulo the buffer depth of 2^AW bytes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cnt_wr_en | input | 1 | Count-byte staging write strobe |
| cnt_wr_sel | input | 2 | Staged byte select (0 low, 1 middle, 2 high) |
| cnt_wr_data | input | 8 | Staged byte value |
| cmd_dma_load | input | 1 | Copy staged bytes into the live counter |
| setup_en | input | 1 | Arm or re-arm a transfer |
| setup_ptr | input | AW | Starting buffer address |
| setup_len | input | LEN_W | Requested length in bytes |
| port_valid | input | 1 | Port access strobe |
| port_write | input | 1 | 1 write, 0 read |
| port_wide | input | 1 | 1 for a 16-bit access |
| port_wdata | input | 16 | Write data |
| port_rdata | output | 16 | Read data, registered |
| drq | output | 1 | Data request |
| done | output | 1 | One-cycle completion pulse |
| rem_len | output | LEN_W | Remaining length |
| cur_ptr | output | AW | Current buffer address |
| xfer_count | output | 24 | Live transfer count |
| tc_flag | output | 1 | Transfer count reached zero |
| bk_we | input | 1 | Back-side buffer write |
| bk_addr | input | AW | Back-side address |
| bk_wdata | input | 8 | Back-side write data |
| bk_rdata | output | 8 | Back-side read data (combinational) |

## Verification
The bench targets the following corner cases:

- **A 16-bit access with one byte left.** A design without clipping would wrap `rem_len` to a huge value and never raise `done`.
- **A live count of one under a wide write.** A design without clipping would wrap the counter and miss `tc_flag`.
- **A zero count armed as 65536.** A design that takes zero literally would never assert `drq`.
- **Writes refused at zero count.** A broken design would corrupt the buffer.
- **A pointer crossing the top of the buffer.**
- **Read-only traffic.** A design sharing the decrement path would wrongly shrink `xfer_count`.

Random mixes of access sizes and directions track a model buffer, and any error in byte order shows up as swapped halves in read data or in back-side contents.

// File: rtl/pdma_pkg.sv
package pdma_pkg;

    localparam int CNT_W   = 24;
    localparam int CNT_NB  = CNT_W / 8;
    localparam int SEL_W   = 2;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_XFER   = 2'd1,
        ST_FINISH = 2'd2
    } pdma_state_e;

    // One accepted access, as seen by the datapath
    typedef struct packed {
        logic       go;
        logic       write;
        logic       wide;
        logic [1:0] nbytes;
    } pdma_acc_t;

endpackage

// File: rtl/pdma_count_regs.sv
module pdma_count_regs
    import pdma_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [SEL_W-1:0] wr_sel,
    input  logic [7:0]       wr_data,
    input  logic             load,
    input  logic             dec_en,
    input  logic [1:0]       dec_amt,
    output logic [CNT_W-1:0] count,
    output logic             tc_flag
);

    logic [CNT_W-1:0] staged;
    logic             sel_valid;

    assign sel_valid = wr_en && (32'(wr_sel) < CNT_NB);

    // One staging byte per counter byte
    for (genvar g = 0; g < CNT_NB; g++) begin : g_stage
        logic [7:0] byte_q;
        always_ff @(posedge clk) begin
            if (!rst_n)
                byte_q <= '0;
            else if (wr_en && (32'(wr_sel) == g))
                byte_q <= wr_data;
        end
        assign staged[g*8 +: 8] = byte_q;
    end

    // Live counter: a load wins over a decrement
    always_ff @(posedge clk) begin
        if (!rst_n)
            count <= '0;
        else if (load)
            count <= staged;
        else if (dec_en)
            count <= count - CNT_W'(dec_amt);
    end

    // Zero-reached flag: a staging write clears it, and that wins
    always_ff @(posedge clk) begin
        if (!rst_n)
            tc_flag <= 1'b0;
        else if (sel_valid)
            tc_flag <= 1'b0;
        else if (!load && dec_en && (count == CNT_W'(dec_amt)))
            tc_flag <= 1'b1;
    end

endmodule

// File: rtl/pdma_byte_buf.sv
module pdma_byte_buf #(
    parameter int AW = 5
) (
    input  logic          clk,
    input  logic          pw_en,
    input  logic          pw_two,
    input  logic [AW-1:0] pw_addr,
    input  logic [7:0]    pw_first,
    input  logic [7:0]    pw_second,
    input  logic          bk_we,
    input  logic [AW-1:0] bk_addr,
    input  logic [7:0]    bk_wdata,
    input  logic [AW-1:0] rd_addr,
    output logic [7:0]    rd_first,
    output logic [7:0]    rd_second,
    output logic [7:0]    bk_rdata
);

    localparam int DEPTH = 1 << AW;

    logic [7:0]    mem [DEPTH];
    logic [AW-1:0] pw_addr_nx;
    logic [AW-1:0] rd_addr_nx;

    // AW-bit sums wrap at the top of the buffer
    assign pw_addr_nx = pw_addr + AW'(1);
    assign rd_addr_nx = rd_addr + AW'(1);

    // The port side is applied last, so it wins a same-address clash
    always_ff @(posedge clk) begin
        if (bk_we)
            mem[bk_addr] <= bk_wdata;
        if (pw_en) begin
            mem[pw_addr] <= pw_first;
            if (pw_two)
                mem[pw_addr_nx] <= pw_second;
        end
    end

    assign rd_first  = mem[rd_addr];
    assign rd_second = mem[rd_addr_nx];
    assign bk_rdata  = mem[bk_addr];

endmodule

// File: rtl/pdma_ctrl.sv
module pdma_ctrl
    import pdma_pkg::*;
#(
    parameter int AW    = 5,
    parameter int LEN_W = 17
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             setup_en,
    input  logic [AW-1:0]    setup_ptr,
    input  logic [LEN_W-1:0] setup_len,
    input  logic [CNT_W-1:0] count,
    input  logic             port_valid,
    input  logic             port_write,
    input  logic             port_wide,
    output pdma_acc_t        acc,
    output logic [AW-1:0]    ptr,
    output logic [LEN_W-1:0] rem,
    output logic             drq,
    output logic             done
);

    localparam logic [CNT_W:0] ZERO_AS = (CNT_W+1)'(32'h0001_0000);

    pdma_state_e      state, state_nx;
    logic [CNT_W:0]   eff_cnt;
    logic [CNT_W:0]   len_ext;
    logic [LEN_W-1:0] rem_load;
    logic [1:0]       nb;
    logic             go;
    logic             drain;

    // Length loaded at setup: the request clipped to the effective count
    always_comb begin
        eff_cnt  = (count == '0) ? ZERO_AS : {1'b0, count};
        len_ext  = (CNT_W+1)'(setup_len);
        rem_load = (len_ext > eff_cnt) ? LEN_W'(eff_cnt) : setup_len;
    end

    // Access acceptance and byte count
    always_comb begin
        nb = port_wide ? 2'd2 : 2'd1;
        if (rem == LEN_W'(1))
            nb = 2'd1;
        if (port_write && (count == CNT_W'(1)))
            nb = 2'd1;
        go = port_valid && !setup_en && (state == ST_XFER)
             && (!port_write || (count != '0));
        drain = go && (rem == LEN_W'(nb));
    end

    assign acc = '{go: go, write: port_write, wide: port_wide, nbytes: nb};

    // Next-state logic
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: begin
                if (setup_en && (rem_load != '0))
                    state_nx = ST_XFER;             // ARM
            end
            ST_XFER: begin
                if (setup_en)
                    state_nx = (rem_load != '0) ? ST_XFER : ST_IDLE; // RELOAD / ABORT
                else if (drain)
                    state_nx = ST_FINISH;           // DRAIN
            end
            ST_FINISH: begin
                if (setup_en && (rem_load != '0))
                    state_nx = ST_XFER;             // ARM
                else
                    state_nx = ST_IDLE;             // RETIRE
            end
            default: state_nx = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n)
            state <= ST_IDLE;
        else
            state <= state_nx;
    end

    // Pointer and remaining length
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr <= '0;
            rem <= '0;
        end else if (setup_en) begin
            ptr <= setup_ptr;
            rem <= rem_load;
        end else if (go) begin
            ptr <= ptr + AW'(nb);
            rem <= rem - LEN_W'(nb);
        end
    end

    // Outputs decoded from the state
    always_comb begin
        drq  = 1'b0;
        done = 1'b0;
        unique case (state)
            ST_IDLE:   ;
            ST_XFER:   drq  = 1'b1;
            ST_FINISH: done = 1'b1;
            default:   ;
        endcase
    end

endmodule

// File: rtl/pdma_port.sv
module pdma_port
    import pdma_pkg::*;
#(
    parameter int AW    = 5,
    parameter int LEN_W = 17
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cnt_wr_en,
    input  logic [1:0]       cnt_wr_sel,
    input  logic [7:0]       cnt_wr_data,
    input  logic             cmd_dma_load,
    input  logic             setup_en,
    input  logic [AW-1:0]    setup_ptr,
    input  logic [LEN_W-1:0] setup_len,
    input  logic             port_valid,
    input  logic             port_write,
    input  logic             port_wide,
    input  logic [15:0]      port_wdata,
    output logic [15:0]      port_rdata,
    output logic             drq,
    output logic             done,
    output logic [LEN_W-1:0] rem_len,
    output logic [AW-1:0]    cur_ptr,
    output logic [23:0]      xfer_count,
    output logic             tc_flag,
    input  logic             bk_we,
    input  logic [AW-1:0]    bk_addr,
    input  logic [7:0]       bk_wdata,
    output logic [7:0]       bk_rdata
);

    pdma_acc_t  acc;
    logic [7:0] rd_first;
    logic [7:0] rd_second;
    logic [7:0] wr_first;
    logic       rd_strobe;

    pdma_count_regs u_cnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (cnt_wr_en),
        .wr_sel  (cnt_wr_sel),
        .wr_data (cnt_wr_data),
        .load    (cmd_dma_load),
        .dec_en  (acc.go && acc.write),
        .dec_amt (acc.nbytes),
        .count   (xfer_count),
        .tc_flag (tc_flag)
    );

    pdma_ctrl #(.AW(AW), .LEN_W(LEN_W)) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .setup_en   (setup_en),
        .setup_ptr  (setup_ptr),
        .setup_len  (setup_len),
        .count      (xfer_count),
        .port_valid (port_valid),
        .port_write (port_write),
        .port_wide  (port_wide),
        .acc        (acc),
        .ptr        (cur_ptr),
        .rem        (rem_len),
        .drq        (drq),
        .done       (done)
    );

    // A wide write sends the high half first
    assign wr_first = port_wide ? port_wdata[15:8] : port_wdata[7:0];

    pdma_byte_buf #(.AW(AW)) u_buf (
        .clk       (clk),
        .pw_en     (acc.go && acc.write),
        .pw_two    (acc.nbytes == 2'd2),
        .pw_addr   (cur_ptr),
        .pw_first  (wr_first),
        .pw_second (port_wdata[7:0]),
        .bk_we     (bk_we),
        .bk_addr   (bk_addr),
        .bk_wdata  (bk_wdata),
        .rd_addr   (cur_ptr),
        .rd_first  (rd_first),
        .rd_second (rd_second),
        .bk_rdata  (bk_rdata)
    );

    assign rd_strobe = port_valid && !port_write;

    // Registered read data; a refused read returns zero
    always_ff @(posedge clk) begin
        if (!rst_n)
            port_rdata <= '0;
        else if (rd_strobe) begin
            if (!acc.go)
                port_rdata <= '0;
            else if (!acc.wide)
                port_rdata <= {8'h00, rd_first};
            else if (acc.nbytes == 2'd2)
                port_rdata <= {rd_first, rd_second};
            else
                port_rdata <= {rd_first, 8'h00};
        end
    end

endmodule

// File: rtl/pdma_port_chk.sv
module pdma_port_chk #(
    parameter int LEN_W = 17
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cmd_dma_load,
    input logic             setup_en,
    input logic             port_valid,
    input logic             port_write,
    input logic             port_wide,
    input logic [15:0]      port_rdata,
    input logic             drq,
    input logic             done,
    input logic [LEN_W-1:0] rem_len,
    input logic [23:0]      xfer_count
);

    a_r10_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    a_r10_done_after_drq: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> $past(drq));

    a_r10_drq_done_apart: assert property (@(posedge clk) disable iff (!rst_n)
        !(drq && done));

    a_r4_drq_has_len: assert property (@(posedge clk) disable iff (!rst_n)
        drq |-> (rem_len != '0));

    a_r7_zero_count_write: assert property (@(posedge clk) disable iff (!rst_n)
        (port_valid && port_write && !cmd_dma_load && !setup_en && (xfer_count == '0))
        |=> (xfer_count == '0));

    a_r8_read_keeps_count: assert property (@(posedge clk) disable iff (!rst_n)
        (port_valid && !port_write && !cmd_dma_load) |=> $stable(xfer_count));

    a_r9_empty_read: assert property (@(posedge clk) disable iff (!rst_n)
        (port_valid && !port_write && !setup_en && (rem_len == '0))
        |=> ((port_rdata == 16'h0) && (rem_len == '0)));

    a_r5_narrow_write_dec: assert property (@(posedge clk) disable iff (!rst_n)
        (port_valid && port_write && !port_wide && !setup_en && !cmd_dma_load
         && (rem_len != '0) && (xfer_count != '0))
        |=> (xfer_count == $past(xfer_count) - 24'd1));

endmodule

bind pdma_port pdma_port_chk #(.LEN_W(LEN_W)) u_chk (.*);

// File: tb/sim_pdma_port.sv
module sim_pdma_port;

    localparam int AW    = 5;
    localparam int DEPTH = 1 << AW;
    localparam int LEN_W = 17;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             cnt_wr_en = 1'b0;
    logic [1:0]       cnt_wr_sel = '0;
    logic [7:0]       cnt_wr_data = '0;
    logic             cmd_dma_load = 1'b0;
    logic             setup_en = 1'b0;
    logic [AW-1:0]    setup_ptr = '0;
    logic [LEN_W-1:0] setup_len = '0;
    logic             port_valid = 1'b0;
    logic             port_write = 1'b0;
    logic             port_wide = 1'b0;
    logic [15:0]      port_wdata = '0;
    logic [15:0]      port_rdata;
    logic             drq, done, tc_flag;
    logic [LEN_W-1:0] rem_len;
    logic [AW-1:0]    cur_ptr;
    logic [23:0]      xfer_count;
    logic             bk_we = 1'b0;
    logic [AW-1:0]    bk_addr = '0;
    logic [7:0]       bk_wdata = '0;
    logic [7:0]       bk_rdata;

    pdma_port #(.AW(AW), .LEN_W(LEN_W)) u0 (.*);

    always #4 clk = ~clk;

    int checks = 0;
    int fails  = 0;
    bit finished = 0;

    // Bench model
    logic [7:0]       m_mem [DEPTH];
    logic [7:0]       m_sh  [3];
    logic [23:0]      m_cnt;
    logic [LEN_W-1:0] m_rem;
    logic [AW-1:0]    m_ptr;
    logic             m_tc;
    logic [15:0]      m_rd;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
        cnt_wr_en = 0; cmd_dma_load = 0; setup_en = 0;
        port_valid = 0; bk_we = 0;
    endtask

    task automatic check_state(input string tag, input bit exp_done);
        chk({tag, " rem"},  32'(rem_len),    32'(m_rem));
        chk({tag, " ptr"},  32'(cur_ptr),    32'(m_ptr));
        chk({tag, " cnt"},  32'(xfer_count), 32'(m_cnt));
        chk({tag, " tc"},   32'(tc_flag),    32'(m_tc));
        chk({tag, "/R10 drq"},  32'(drq),  32'(m_rem != 0));
        chk({tag, "/R10 done"}, 32'(done), 32'(exp_done));
    endtask

    function automatic logic [LEN_W-1:0] exp_load(input logic [23:0] c, input logic [LEN_W-1:0] l);
        logic [24:0] eff;
        eff = (c == 0) ? 25'h1_0000 : {1'b0, c};
        return ({8'h0, l} > eff) ? LEN_W'(eff) : l;
    endfunction

    task automatic op_cnt_wr(input logic [1:0] sel, input logic [7:0] v);
        cnt_wr_en = 1; cnt_wr_sel = sel; cnt_wr_data = v;
        tick();
        if (sel < 3) begin
            m_sh[sel] = v;
            m_tc = 0;
        end
        check_state((sel < 3) ? "R3" : "R2", 0);
    endtask

    task automatic op_load();
        cmd_dma_load = 1;
        tick();
        m_cnt = {m_sh[2], m_sh[1], m_sh[0]};
        check_state("R2", 0);
    endtask

    task automatic op_setup(input logic [AW-1:0] p, input logic [LEN_W-1:0] l);
        setup_en = 1; setup_ptr = p; setup_len = l;
        tick();
        m_rem = exp_load(m_cnt, l);
        m_ptr = p;
        check_state("R4", 0);
    endtask

    task automatic op_bk_wr(input logic [AW-1:0] a, input logic [7:0] d);
        bk_we = 1; bk_addr = a; bk_wdata = d;
        tick();
        m_mem[a] = d;
    endtask

    task automatic op_idle();
        tick();
        check_state("R10", 0);
    endtask

    task automatic op_access(input bit wr, input bit wide, input logic [15:0] d);
        logic [AW-1:0] p;
        logic [1:0]    n;
        bit            acc;
        bit            drained;
        string         t;
        p = m_ptr;
        acc = (m_rem != 0) && (!wr || m_cnt != 0);
        n = wide ? 2'd2 : 2'd1;
        if (m_rem == 1) n = 2'd1;
        if (wr && m_cnt == 1) n = 2'd1;
        t = wr ? (wide ? "R6" : "R5") : "R8";
        if (!acc) t = wr ? "R7" : "R9";
        drained = 0;
        port_valid = 1; port_write = wr; port_wide = wide; port_wdata = d;
        tick();
        if (acc) begin
            if (wr) begin
                m_mem[p] = wide ? d[15:8] : d[7:0];
                if (n == 2) m_mem[p + AW'(1)] = d[7:0];
                m_cnt = m_cnt - 24'(n);
                if (m_cnt == 0) m_tc = 1;
            end else begin
                if (!wide)       m_rd = {8'h00, m_mem[p]};
                else if (n == 2) m_rd = {m_mem[p], m_mem[p + AW'(1)]};
                else             m_rd = {m_mem[p], 8'h00};
            end
            m_rem = m_rem - LEN_W'(n);
            m_ptr = m_ptr + AW'(n);
            drained = (m_rem == 0);
        end else if (!wr) begin
            m_rd = 16'h0;
        end
        check_state(t, drained);
        if (!wr) chk({t, " rdata"}, 32'(port_rdata), 32'(m_rd));
        if (wr) begin
            bk_addr = p; #1;
            chk({t, "/R12 buf"}, 32'(bk_rdata), 32'(m_mem[p]));
            bk_addr = p + AW'(1); #1;
            chk({t, "/R12 buf+1"}, 32'(bk_rdata), 32'(m_mem[p + AW'(1)]));
        end
    endtask

    task automatic set_count(input logic [7:0] lo, input logic [7:0] mid, input logic [7:0] hi);
        op_cnt_wr(2'd0, lo);
        op_cnt_wr(2'd1, mid);
        op_cnt_wr(2'd2, hi);
        op_load();
    endtask

    initial begin
        #(8 * 150000);
        if (!finished) begin
            fails++;
            checks++;
            $display("FAIL watchdog expired");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end

    initial begin
        m_cnt = 0; m_rem = 0; m_ptr = 0; m_tc = 0; m_rd = 0;
        for (int i = 0; i < 3; i++) m_sh[i] = 0;
        repeat (3) @(posedge clk);
        #1 rst_n = 1;
        // R1: reset state
        chk("R1 drq", 32'(drq), 0);
        chk("R1 done", 32'(done), 0);
        chk("R1 rem", 32'(rem_len), 0);
        chk("R1 ptr", 32'(cur_ptr), 0);
        chk("R1 cnt", 32'(xfer_count), 0);
        chk("R1 tc", 32'(tc_flag), 0);
        chk("R1 rdata", 32'(port_rdata), 0);
        for (int i = 0; i < DEPTH; i++) op_bk_wr(AW'(i), 8'(i * 7 + 3));

        // R2: staging does not touch the live counter; select 3 ignored
        op_cnt_wr(2'd0, 8'h05);
        op_cnt_wr(2'd1, 8'h00);
        op_cnt_wr(2'd2, 8'h00);
        op_cnt_wr(2'd3, 8'hFF);
        op_load();
        // R4: length clipped to the count
        op_setup(AW'(2), LEN_W'(10));
        op_access(1, 0, 16'h003C);   // R5
        op_access(1, 1, 16'h1234);   // R6
        op_access(1, 1, 16'hABCD);   // R6 drain, R11, R10
        op_idle();
        // R3: staging write clears tc_flag
        op_cnt_wr(2'd0, 8'h00);
        op_load();
        // R4: zero count taken as 65536
        op_setup(AW'(0), LEN_W'(70000));
        op_access(1, 0, 16'h00EE);   // R7: count zero, refused
        op_access(0, 0, 16'h0);      // R8: read, count unchanged
        op_access(0, 1, 16'h0);      // R8: wide read
        // R9: empty read
        op_setup(AW'(0), LEN_W'(0));
        op_access(0, 1, 16'h0);
        op_access(1, 1, 16'h5555);   // R7: rem zero
        // R12: wrap across the top
        set_count(8'h06, 8'h00, 8'h00);
        op_setup(AW'(DEPTH - 1), LEN_W'(4));
        op_access(1, 1, 16'hA1B2);
        op_setup(AW'(DEPTH - 1), LEN_W'(4));
        op_access(0, 1, 16'h0);
        // R6: live count of 1 clips a wide write
        set_count(8'd20, 8'h00, 8'h00);
        op_setup(AW'(5), LEN_W'(8));
        op_cnt_wr(2'd0, 8'h01);
        op_load();
        op_access(1, 1, 16'hC3D4);
        op_access(1, 0, 16'h0077);   // R7
        // R8: wide read with one byte left
        op_setup(AW'(9), LEN_W'(1));
        op_access(0, 1, 16'h0);
        op_idle();

        // Random phase
        void'($urandom(32'd20240607));
        for (int r = 0; r < 40; r++) begin
            set_count(8'($urandom_range(0, 40)),
                      ($urandom_range(0, 7) == 0) ? 8'h01 : 8'h00, 8'h00);
            op_setup(AW'($urandom_range(0, DEPTH - 1)), LEN_W'($urandom_range(0, 45)));
            for (int k = 0; k < 90; k++) begin
                if (m_rem == 0) break;
                if ($urandom_range(0, 9) == 0)
                    op_bk_wr(AW'($urandom_range(0, DEPTH - 1)), 8'($urandom));
                else
                    op_access(1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)),
                              16'($urandom));
            end
            op_idle();
        end

        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

endmodule